// File: doc/BRIEF.md
# Operand Address Generator

This block sits between instruction decode and execution in a 16-bit processor with a memory-to-memory instruction set. When told to start, it captures the instruction word and the program counter and reads the operand-count class from the two top bits. For single-operand instructions it resolves the three-bit addressing mode against the destination register field. When the mode needs a trailing instruction word, the block fetches it through a synchronous memory read port and advances the program counter past it. For the indirect modes it also performs one pointer read.

The result is a single 16-bit operand word and a flag that tells whether the word is an operand value or a memory address. A one-cycle done strobe marks that result. The block also presents the low four bits of that word as a ready-made shift count. The register file read is combinational and selected by the block. The memory returns data one cycle after a request.

Top module: `opnd_addr_gen`

## Requirements
- R1: The class is ir[15:14]. Any class other than 01 does no address generation: done is pulsed two clock edges after the start edge, with opnd = 0, opnd_is_addr = 0, no memory read and pc_out equal to the captured PC.
- R2: For class 01, MODE is ir[9:7] and the register field is ir[2:0]. MODE 000 yields the register value as a value, and MODE 001 yields it as an address. Neither reads memory or moves pc_out, and done comes two edges after start.
- R3: Every MODE with MODE[2:1] not 00 reads exactly one trailing word W at the captured PC, and pc_out then equals PC + 1 (mod 2^16).
- R4: MODE 010 (immediate) yields W as a value after one memory read, with done three edges after start.
- R5: MODE 011 (direct) yields W as an address, with no further memory read.
- R6: MODE 100 (indexed) yields register + W (mod 2^16) as an address, with done three edges after start.
- R7: MODE 110 (PC-relative) yields (PC + 1) + W (mod 2^16) as an address.
- R8: MODE 101 and 111 read memory once more at the address that R6 or R7 would give. The word read back is returned as an address, after two reads in total, with done five edges after start.
- R9: done is high for exactly one cycle per operation, the block is idle in that cycle, and the memory data is used one cycle after its request.
- R10: shamt always equals the low four bits of opnd, so shift amounts of 16 or more are reduced modulo 16.
- R11: start is ignored while busy is high, and changes on ir or pc_in during an operation do not alter its result.
- R12: After reset, busy, done and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin processing ir and pc_in when idle |
| ir | input | 16 | Instruction word |
| pc_in | input | 16 | PC pointing at the possible trailing word |
| reg_sel | output | 3 | Register file read select |
| reg_rdata | input | 16 | Register file read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory data, valid one cycle after a request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| opnd | output | 16 | Operand value or effective address |
| opnd_is_addr | output | 1 | 1 when opnd is an address |
| opnd_class | output | 2 | Operand-count class of the captured instruction |
| shamt | output | 4 | Low four bits of opnd as a shift count |
| pc_out | output | 16 | Updated program counter |

## Verification
The assertions check, on every cycle, that done lasts one cycle and finds the block idle. They also check that memory is never requested outside an operation or for a class without address generation, and that the program counter moves by at most one during an operation. The bench scenarios are needed to show the actual address arithmetic for each mode, including wrap-around, and the number of reads and edges each mode takes. They also show that a start or instruction change arriving mid-operation leaves the result unchanged.

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] ir,
  input  logic [DW-1:0] pc_in,
  output logic [RW-1:0] reg_sel,
  input  logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] opnd,
  output logic          opnd_is_addr,
  output logic [1:0]    opnd_class,
  output logic [3:0]    shamt,
  output logic [DW-1:0] pc_out
);
  localparam int MLO = 2*RW + 1;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_W, S_I, S_IW} st_t;
  st_t st;

  logic [DW-1:0] ir_q, pc_q, base_q, ptr_q, pc_nx, calc;
  logic [2:0]    mode;
  logic [1:0]    typ;
  logic          ind, one_op;

  assign opnd_class = ir_q[DW-1:DW-2];
  assign mode       = ir_q[MLO+2:MLO];
  assign typ        = mode[2:1];
  assign ind        = mode[0];
  assign one_op     = opnd_class == 2'b01;
  assign reg_sel    = ir_q[RW-1:0];
  assign busy       = st != S_IDLE;
  assign mem_req    = (st == S_DEC && one_op && typ != 2'b00) || st == S_I;
  assign mem_addr   = (st == S_I) ? ptr_q : pc_q;
  assign pc_nx      = pc_q + 1'b1;
  assign pc_out     = pc_q;
  assign shamt      = opnd[3:0];
  assign calc       = (typ == 2'b10) ? base_q + mem_rdata :
                      (typ == 2'b11) ? pc_nx + mem_rdata : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      ir_q         <= '0;
      pc_q         <= '0;
      base_q       <= '0;
      ptr_q        <= '0;
      opnd         <= '0;
      opnd_is_addr <= 1'b0;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ir_q <= ir;
          pc_q <= pc_in;
          st   <= S_DEC;
        end
        S_DEC: begin
          base_q <= reg_rdata;
          if (!one_op) begin
            opnd         <= '0;
            opnd_is_addr <= 1'b0;
            done         <= 1'b1;
            st           <= S_IDLE;
          end else if (typ == 2'b00) begin
            opnd         <= reg_rdata;
            opnd_is_addr <= ind;
            done         <= 1'b1;
            st           <= S_IDLE;
          end else begin
            st <= S_W;
          end
        end
        S_W: begin
          pc_q <= pc_nx;
          if (typ == 2'b01 || !ind) begin
            opnd         <= calc;
            opnd_is_addr <= (typ != 2'b01) | ind;
            done         <= 1'b1;
            st           <= S_IDLE;
          end else begin
            ptr_q <= calc;
            st    <= S_I;
          end
        end
        S_I: st <= S_IW;
        S_IW: begin
          opnd         <= mem_rdata;
          opnd_is_addr <= 1'b1;
          done         <= 1'b1;
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module opnd_addr_gen_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic [1:0]    opnd_class,
  input logic [DW-1:0] pc_out
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_req_in_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  p_no_req_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && opnd_class != 2'b01) |-> !mem_req);
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (pc_out == $past(pc_out) || pc_out == $past(pc_out) + 16'd1));
endmodule

bind opnd_addr_gen opnd_addr_gen_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_req(mem_req), .opnd_class(opnd_class), .pc_out(pc_out)
);

// File: tb/opnd_addr_gen_tb.sv
module opnd_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ir = '0, pc_in = '0;
  logic [2:0]  reg_sel;
  logic [15:0] reg_rdata, mem_addr, opnd, pc_out;
  logic [15:0] mem_rdata = '0;
  logic        mem_req, busy, done, opnd_is_addr;
  logic [1:0]  opnd_class;
  logic [3:0]  shamt;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  opnd_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ir(ir), .pc_in(pc_in),
    .reg_sel(reg_sel), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .opnd(opnd), .opnd_is_addr(opnd_is_addr), .opnd_class(opnd_class),
    .shamt(shamt), .pc_out(pc_out)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return a * 16'd7 + 16'h1234;
  endfunction
  function automatic logic [15:0] regf(input logic [2:0] i);
    return {1'b0, i, 12'h0A5};
  endfunction

  assign reg_rdata = regf(reg_sel);
  always @(posedge clk) mem_rdata <= memf(mem_addr);

  function automatic void model(input logic [15:0] x, input logic [15:0] pc,
      output logic [15:0] eo, output logic ea, output logic [15:0] ep,
      output int el, output int er, output string tg);
    logic [2:0]  m;
    logic [15:0] w, a;
    m = x[9:7];
    ep = pc; eo = '0; ea = 1'b0; el = 2; er = 0; tg = "R1";
    if (x[15:14] != 2'b01) return;
    if (m[2:1] == 2'b00) begin
      eo = regf(x[2:0]); ea = m[0]; tg = "R2"; return;
    end
    w = memf(pc); ep = pc + 16'd1; el = 3; er = 1;
    if (m[2:1] == 2'b01) begin
      eo = w; ea = m[0]; tg = m[0] ? "R5" : "R4"; return;
    end
    a = (m[2:1] == 2'b10) ? regf(x[2:0]) + w : pc + 16'd1 + w;
    ea = 1'b1;
    if (m[0]) begin
      eo = memf(a); el = 5; er = 2; tg = "R8";
    end else begin
      eo = a; tg = (m[2:1] == 2'b10) ? "R6" : "R7";
    end
  endfunction

  task automatic chk(input logic ok, input string tg, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] x, input logic [15:0] pc, input int hold);
    logic [15:0] eo, ep;
    logic ea;
    int el, er, lat, rd;
    string tg;
    model(x, pc, eo, ea, ep, el, er, tg);
    @(negedge clk);
    ir = x; pc_in = pc; start = 1'b1;
    lat = 0; rd = 0;
    while (lat < 20) begin
      if (mem_req) rd++;
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat >= hold) start = 1'b0;
      if (hold > 1) begin ir = ~x; pc_in = ~pc; end
      if (done) break;
    end
    chk(done, tg, "done", {31'd0, done}, 32'd1);
    chk(lat == el, (tg == "R1" || tg == "R2") ? tg : "R9", "latency", lat, el);
    chk(rd == er, "R3", "reads", rd, er);
    chk(opnd == eo, tg, "opnd", {16'd0, opnd}, {16'd0, eo});
    chk(opnd_is_addr == ea, tg, "is_addr", {31'd0, opnd_is_addr}, {31'd0, ea});
    chk(pc_out == ep, "R3", "pc_out", {16'd0, pc_out}, {16'd0, ep});
    chk(shamt == eo[3:0], "R10", "shamt", {28'd0, shamt}, {28'd0, eo[3:0]});
    chk(!busy, "R9", "busy_at_done", {31'd0, busy}, 32'd0);
    ir = '0;
    @(negedge clk);
    chk(!done, "R9", "done_pulse", {31'd0, done}, 32'd0);
  endtask

  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {2'b01, 3'b000, 3'd3, 16'h0040},
    {2'b01, 3'b001, 3'd5, 16'h0041},
    {2'b01, 3'b010, 3'd0, 16'h0050},
    {2'b01, 3'b011, 3'd1, 16'h0051},
    {2'b01, 3'b100, 3'd2, 16'h0060},
    {2'b01, 3'b101, 3'd7, 16'h0061},
    {2'b01, 3'b110, 3'd4, 16'h0070},
    {2'b01, 3'b111, 3'd6, 16'h0071},
    {2'b00, 3'b100, 3'd2, 16'h0080},
    {2'b10, 3'b010, 3'd1, 16'h0090},
    {2'b01, 3'b110, 3'd1, 16'hFFF8},
    {2'b01, 3'b100, 3'd7, 16'h3000},
    {2'b11, 3'b000, 3'd0, 16'h0000}
  };

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R12", "reset_state",
        {29'd0, busy, done, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R12", "idle_after_reset",
        {29'd0, busy, done, mem_req}, 32'd0);
    for (int i = 0; i < NV; i++) begin
      logic [15:0] x;
      x = {VEC[i][23:22], i[3:0], VEC[i][21:19], 1'b1, 3'd6, VEC[i][18:16]};
      run(x, VEC[i][15:0], 1);
    end
    // R11: start held and ir/pc_in changed while busy
    run({2'b01, 4'h3, 3'b101, 1'b0, 3'd1, 3'd2}, 16'h0200, 3);
    run({2'b01, 4'h4, 3'b111, 1'b0, 3'd0, 3'd0}, 16'hFFFF, 4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule